// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block is a host-side master that carries one command transaction through a memory-mapped mailbox. A requester presents a command byte, a 4-bit subcommand, up to sixteen input bytes with their length, a count of 32-bit reply words, and two 32-bit pointer values. The block first checks the lengths. It then loads the pointer registers, the input words and finally the command word. Next it waits for the responder to finish, and on success it collects the reply words.

Two wait styles are available per request. In interrupt style, the command word asks for a completion pulse, and the block waits a bounded number of cycles for `cmpIrq`. In polling style, it rereads the status register until the busy flag drops, up to a bounded number of reads. A "simple" request sends only the command word, with a zero length field, and reads nothing back. Each transaction ends with a one-cycle `done` strobe and a result code.

Top module: `mbox_cmd_seq`

## Requirements
- R1: A request is taken when `reqValid` is high and `busy` is low. `busy` is high from the next cycle through the `done` cycle, and `reqValid` pulses while `busy` is high are ignored.
- R2: A non-simple request with `reqInLen` above 16 or `reqOutCnt` above 4 ends with result 1 (invalid), makes no bus access, and raises `done` in the cycle after acceptance.
- R3: A non-simple request writes in this order: 0x00C gets the destination pointer, 0x008 gets the source pointer, ceil(inLen/4) words go to 0x080+4*i in ascending i (word i is `reqData[32*i+31:32*i]`), and the command word goes to 0x000 last.
- R4: The command word is inLen in bits 23:16, the subcommand in bits 15:12, bit 8 set only in interrupt style, and the command in bits 7:0.
- R5: A simple request skips the length check and the pointer and data writes. It writes a command word with a zero length field and reads no reply words.
- R6: In polling style, status at 0x004 is read until bit 0 (busy) reads clear. If POLL_LIMIT reads all show busy, the result is 2 (timeout) and no reply word is read.
- R7: In interrupt style, a `cmpIrq` pulse within IRQ_WAIT cycles after the command write is followed by one status read. A pulse in the last allowed cycle still counts. Without a pulse, the result is 2 with no read at all.
- R8: If status bit 1 (error) is set, bits 23:16 give a code. Codes 6 and 7 give result 4 (access denied), and any other code gives result 3 (I/O error). No reply word is read in either case.
- R9: On a clean status, reqOutCnt words are read from 0x090+4*i in ascending i and placed at `outData[32*i+31:32*i]` (other words zero), and the result is 0 (ok).
- R10: While `busValid` is high and `busReady` low, `busAddr`, `busWrite` and `busWData` stay unchanged.
- R11: `done` lasts one cycle. `result` stays unchanged while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqSimple | input | 1 | Command-only request |
| reqUseIrq | input | 1 | Wait for completion pulse instead of polling |
| reqCmd | input | 8 | Command byte |
| reqSub | input | 4 | Subcommand |
| reqInLen | input | 5 | Input length in bytes |
| reqOutCnt | input | 3 | Reply words wanted |
| reqData | input | 128 | Input bytes, byte 0 in bits 7:0 |
| reqDstPtr | input | 32 | Destination pointer value |
| reqSrcPtr | input | 32 | Source pointer value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 3 | 0 ok, 1 invalid, 2 timeout, 3 I/O error, 4 denied |
| outData | output | 128 | Reply words |
| busValid | output | 1 | Bus access request |
| busWrite | output | 1 | Access is a write |
| busAddr | output | 12 | Register offset |
| busWData | output | 32 | Write data |
| busReady | input | 1 | Access completes this cycle |
| busRData | input | 32 | Read data, valid with busReady |
| cmpIrq | input | 1 | Completion pulse from the responder |

## Verification
Two events can land in the same cycle. One is the completion pulse arriving and the other is the interrupt wait running out, or in polling style, the final allowed status read coming back not busy. The bench fires the pulse exactly in the last waiting cycle and then one cycle later. It expects success with a single status read in the first case, and a timeout with no read in the second. For polling, it makes the responder report busy for one read fewer than the limit and then for exactly the limit, and judges the outcome by the result code and the logged count of status reads.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    RES_OK = 3'd0, RES_INVALID = 3'd1, RES_TIMEOUT = 3'd2,
    RES_IOERR = 3'd3, RES_DENIED = 3'd4
  } result_e;

  typedef enum logic [2:0] {
    SEL_DPTR, SEL_SPTR, SEL_DATA, SEL_CMD, SEL_STS, SEL_OUT
  } busSel_e;

  typedef struct packed {
    logic    loadReq;
    logic    clrIdx;
    logic    incIdx;
    logic    clrWait;
    logic    incWait;
    logic    captureOut;
    logic    setResult;
    result_e resCode;
  } ctrlStrobe_t;

  localparam logic [11:0] OFS_CMD  = 12'h000;
  localparam logic [11:0] OFS_STS  = 12'h004;
  localparam logic [11:0] OFS_SPTR = 12'h008;
  localparam logic [11:0] OFS_DPTR = 12'h00C;
  localparam logic [11:0] OFS_WBUF = 12'h080;
  localparam logic [11:0] OFS_RBUF = 12'h090;
  localparam int STS_BUSY_BIT = 0;
  localparam int STS_ERR_BIT  = 1;
  localparam int CMD_IRQ_BIT  = 8;
  localparam logic [7:0] DENY_CODE_A = 8'd6;
  localparam logic [7:0] DENY_CODE_B = 8'd7;
endpackage

// File: rtl/mbox_seq_dpath.sv
module mbox_seq_dpath
  import mbox_pkg::*;
#(
  parameter int MAX_IN_BYTES  = 16,
  parameter int MAX_OUT_WORDS = 4,
  parameter int POLL_LIMIT    = 1000,
  parameter int IRQ_WAIT      = 4000,
  parameter int ADDR_W        = 12,
  localparam int LEN_W   = $clog2(MAX_IN_BYTES + 1),
  localparam int OCNT_W  = $clog2(MAX_OUT_WORDS + 1),
  localparam int IN_W    = 8 * MAX_IN_BYTES,
  localparam int OUT_W   = 32 * MAX_OUT_WORDS,
  localparam int IN_WRDS = (MAX_IN_BYTES + 3) / 4,
  localparam int IDX_W   = $clog2((IN_WRDS > MAX_OUT_WORDS ? IN_WRDS : MAX_OUT_WORDS) + 1),
  localparam int WMAX    = POLL_LIMIT > IRQ_WAIT ? POLL_LIMIT : IRQ_WAIT,
  localparam int WAIT_W  = $clog2(WMAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  busSel_e           sel,
  input  logic              reqSimple,
  input  logic              reqUseIrq,
  input  logic [7:0]        reqCmd,
  input  logic [3:0]        reqSub,
  input  logic [LEN_W-1:0]  reqInLen,
  input  logic [OCNT_W-1:0] reqOutCnt,
  input  logic [IN_W-1:0]   reqData,
  input  logic [31:0]       reqDstPtr,
  input  logic [31:0]       reqSrcPtr,
  input  logic [31:0]       busRData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWData,
  output logic              reqBad,
  output logic              useIrq,
  output logic              hasInWords,
  output logic              hasOutWords,
  output logic              lastIn,
  output logic              lastOut,
  output logic              waitDone,
  output logic              pollDone,
  output logic              stsBusy,
  output logic              stsErr,
  output logic [7:0]        stsCode,
  output result_e           result,
  output logic [OUT_W-1:0]  outData
);
  logic [7:0]        cmdR;
  logic [3:0]        subR;
  logic [LEN_W-1:0]  inLenR;
  logic [OCNT_W-1:0] outCntR;
  logic [IN_W-1:0]   dataR;
  logic [31:0]       dptrR, sptrR;
  logic              simpleR;
  logic [IDX_W-1:0]  idx;
  logic [WAIT_W-1:0] waitCnt;
  logic [LEN_W-1:0]  effLen;
  logic [OCNT_W-1:0] effOut;
  int                inWords;
  logic [31:0]       cmdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdR <= '0; subR <= '0; inLenR <= '0; outCntR <= '0; dataR <= '0;
      dptrR <= '0; sptrR <= '0; simpleR <= 1'b0; useIrq <= 1'b0;
      idx <= '0; waitCnt <= '0; result <= RES_OK; outData <= '0;
    end else begin
      if (stb.loadReq) begin
        cmdR <= reqCmd; subR <= reqSub; inLenR <= reqInLen; outCntR <= reqOutCnt;
        dataR <= reqData; dptrR <= reqDstPtr; sptrR <= reqSrcPtr;
        simpleR <= reqSimple; useIrq <= reqUseIrq; outData <= '0;
      end
      if (stb.clrIdx) idx <= '0;
      else if (stb.incIdx) idx <= idx + 1'b1;
      if (stb.clrWait) waitCnt <= '0;
      else if (stb.incWait) waitCnt <= waitCnt + 1'b1;
      if (stb.captureOut) outData[32*int'(idx) +: 32] <= busRData;
      if (stb.setResult) result <= stb.resCode;
    end
  end

  assign reqBad = !reqSimple &&
                  (int'(reqInLen) > MAX_IN_BYTES || int'(reqOutCnt) > MAX_OUT_WORDS);
  assign effLen      = simpleR ? '0 : inLenR;
  assign effOut      = simpleR ? '0 : outCntR;
  assign inWords     = (int'(effLen) + 3) / 4;
  assign hasInWords  = inWords != 0;
  assign hasOutWords = effOut != '0;
  assign lastIn      = int'(idx) + 1 >= inWords;
  assign lastOut     = int'(idx) + 1 >= int'(effOut);
  assign waitDone    = int'(waitCnt) >= IRQ_WAIT - 1;
  assign pollDone    = int'(waitCnt) >= POLL_LIMIT - 1;
  assign stsBusy     = busRData[STS_BUSY_BIT];
  assign stsErr      = busRData[STS_ERR_BIT];
  assign stsCode     = busRData[23:16];

  assign cmdWord = (32'(effLen) << 16) | (32'(subR) << 12) |
                   (32'(useIrq) << CMD_IRQ_BIT) | 32'(cmdR);

  always_comb begin
    busAddr  = ADDR_W'(OFS_CMD);
    busWData = '0;
    case (sel)
      SEL_DPTR: begin busAddr = ADDR_W'(OFS_DPTR); busWData = dptrR; end
      SEL_SPTR: begin busAddr = ADDR_W'(OFS_SPTR); busWData = sptrR; end
      SEL_DATA: begin
        busAddr  = ADDR_W'(int'(OFS_WBUF) + 4 * int'(idx));
        busWData = dataR[32*int'(idx) +: 32];
      end
      SEL_CMD:  busWData = cmdWord;
      SEL_STS:  busAddr = ADDR_W'(OFS_STS);
      SEL_OUT:  busAddr = ADDR_W'(int'(OFS_RBUF) + 4 * int'(idx));
      default:  busAddr = ADDR_W'(OFS_CMD);
    endcase
  end
endmodule

// File: rtl/mbox_seq_ctrl.sv
module mbox_seq_ctrl
  import mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqSimple,
  input  logic        reqBad,
  input  logic        useIrq,
  input  logic        hasInWords,
  input  logic        hasOutWords,
  input  logic        lastIn,
  input  logic        lastOut,
  input  logic        waitDone,
  input  logic        pollDone,
  input  logic        stsBusy,
  input  logic        stsErr,
  input  logic [7:0]  stsCode,
  input  logic        cmpIrq,
  input  logic        busReady,
  output logic        busValid,
  output logic        busWrite,
  output busSel_e     sel,
  output ctrlStrobe_t stb,
  output logic        busy,
  output logic        done
);
  typedef enum logic [3:0] {
    S_IDLE, S_DPTR, S_SPTR, S_DATA, S_CMD, S_WIRQ, S_STS, S_POLL, S_OUT, S_DONE
  } state_e;
  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state; stb = '0; busValid = 1'b0; busWrite = 1'b0; sel = SEL_CMD;
    case (state)
      S_IDLE: if (reqValid) begin
        stb.loadReq = 1'b1; stb.clrIdx = 1'b1; stb.clrWait = 1'b1;
        if (reqBad) begin
          stb.setResult = 1'b1; stb.resCode = RES_INVALID; nxt = S_DONE;
        end else nxt = reqSimple ? S_CMD : S_DPTR;
      end
      S_DPTR: begin
        busValid = 1'b1; busWrite = 1'b1; sel = SEL_DPTR;
        if (busReady) nxt = S_SPTR;
      end
      S_SPTR: begin
        busValid = 1'b1; busWrite = 1'b1; sel = SEL_SPTR;
        if (busReady) nxt = hasInWords ? S_DATA : S_CMD;
      end
      S_DATA: begin
        busValid = 1'b1; busWrite = 1'b1; sel = SEL_DATA;
        if (busReady) begin
          if (lastIn) begin stb.clrIdx = 1'b1; nxt = S_CMD; end
          else stb.incIdx = 1'b1;
        end
      end
      S_CMD: begin
        busValid = 1'b1; busWrite = 1'b1; sel = SEL_CMD;
        if (busReady) begin stb.clrWait = 1'b1; nxt = useIrq ? S_WIRQ : S_POLL; end
      end
      S_WIRQ: begin
        if (cmpIrq) nxt = S_STS;
        else if (waitDone) begin
          stb.setResult = 1'b1; stb.resCode = RES_TIMEOUT; nxt = S_DONE;
        end else stb.incWait = 1'b1;
      end
      S_STS, S_POLL: begin
        busValid = 1'b1; sel = SEL_STS;
        if (busReady) begin
          if (state == S_POLL && stsBusy) begin
            if (pollDone) begin
              stb.setResult = 1'b1; stb.resCode = RES_TIMEOUT; nxt = S_DONE;
            end else stb.incWait = 1'b1;
          end else if (stsErr) begin
            stb.setResult = 1'b1; nxt = S_DONE;
            stb.resCode = (stsCode == DENY_CODE_A || stsCode == DENY_CODE_B)
                          ? RES_DENIED : RES_IOERR;
          end else if (hasOutWords) begin
            stb.clrIdx = 1'b1; nxt = S_OUT;
          end else begin
            stb.setResult = 1'b1; stb.resCode = RES_OK; nxt = S_DONE;
          end
        end
      end
      S_OUT: begin
        busValid = 1'b1; sel = SEL_OUT;
        if (busReady) begin
          stb.captureOut = 1'b1;
          if (lastOut) begin
            stb.setResult = 1'b1; stb.resCode = RES_OK; nxt = S_DONE;
          end else stb.incIdx = 1'b1;
        end
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = state != S_IDLE;
  assign done = state == S_DONE;
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_pkg::*;
#(
  parameter int MAX_IN_BYTES  = 16,
  parameter int MAX_OUT_WORDS = 4,
  parameter int POLL_LIMIT    = 1000,
  parameter int IRQ_WAIT      = 4000,
  parameter int ADDR_W        = 12,
  localparam int LEN_W  = $clog2(MAX_IN_BYTES + 1),
  localparam int OCNT_W = $clog2(MAX_OUT_WORDS + 1),
  localparam int IN_W   = 8 * MAX_IN_BYTES,
  localparam int OUT_W  = 32 * MAX_OUT_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqSimple,
  input  logic              reqUseIrq,
  input  logic [7:0]        reqCmd,
  input  logic [3:0]        reqSub,
  input  logic [LEN_W-1:0]  reqInLen,
  input  logic [OCNT_W-1:0] reqOutCnt,
  input  logic [IN_W-1:0]   reqData,
  input  logic [31:0]       reqDstPtr,
  input  logic [31:0]       reqSrcPtr,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  output logic [OUT_W-1:0]  outData,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWData,
  input  logic              busReady,
  input  logic [31:0]       busRData,
  input  logic              cmpIrq
);
  ctrlStrobe_t stb;
  busSel_e     sel;
  result_e     resR;
  logic reqBad, useIrq, hasInWords, hasOutWords, lastIn, lastOut;
  logic waitDone, pollDone, stsBusy, stsErr;
  logic [7:0] stsCode;

  mbox_seq_dpath #(
    .MAX_IN_BYTES(MAX_IN_BYTES), .MAX_OUT_WORDS(MAX_OUT_WORDS),
    .POLL_LIMIT(POLL_LIMIT), .IRQ_WAIT(IRQ_WAIT), .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sel(sel),
    .reqSimple(reqSimple), .reqUseIrq(reqUseIrq), .reqCmd(reqCmd), .reqSub(reqSub),
    .reqInLen(reqInLen), .reqOutCnt(reqOutCnt), .reqData(reqData),
    .reqDstPtr(reqDstPtr), .reqSrcPtr(reqSrcPtr), .busRData(busRData),
    .busAddr(busAddr), .busWData(busWData), .reqBad(reqBad), .useIrq(useIrq),
    .hasInWords(hasInWords), .hasOutWords(hasOutWords), .lastIn(lastIn),
    .lastOut(lastOut), .waitDone(waitDone), .pollDone(pollDone),
    .stsBusy(stsBusy), .stsErr(stsErr), .stsCode(stsCode),
    .result(resR), .outData(outData)
  );

  mbox_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSimple(reqSimple),
    .reqBad(reqBad), .useIrq(useIrq), .hasInWords(hasInWords),
    .hasOutWords(hasOutWords), .lastIn(lastIn), .lastOut(lastOut),
    .waitDone(waitDone), .pollDone(pollDone), .stsBusy(stsBusy),
    .stsErr(stsErr), .stsCode(stsCode), .cmpIrq(cmpIrq), .busReady(busReady),
    .busValid(busValid), .busWrite(busWrite), .sel(sel), .stb(stb),
    .busy(busy), .done(done)
  );

  assign result = resR;
endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              done,
  input logic [2:0]        result,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWData,
  input logic              busReady
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy |=> busy);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busValid);
  // R2
  invalid_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && result == 3'd1 |-> $past(reqValid && !busy));
  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busAddr) &&
                              $stable(busWrite) && $stable(busWData));
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && $past(!busy) |-> $stable(result));
endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done),
  .result(result), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWData(busWData), .busReady(busReady)
);

// File: tb/mbox_cmd_seq_bench.sv
module mbox_cmd_seq_bench;
  localparam int PL = 5;
  localparam int IW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqSimple = 1'b0, reqUseIrq = 1'b0;
  logic [7:0] reqCmd = '0;
  logic [3:0] reqSub = '0;
  logic [4:0] reqInLen = '0;
  logic [2:0] reqOutCnt = '0;
  logic [127:0] reqData;
  logic [31:0] reqDstPtr = '0, reqSrcPtr = '0;
  logic busy, done, busValid, busWrite;
  logic [2:0] result;
  logic [127:0] outData;
  logic [11:0] busAddr;
  logic [31:0] busWData;
  logic busReady = 1'b0, cmpIrq = 1'b0;
  logic [31:0] busRData = '0;

  int errors = 0, checks = 0;
  bit finished = 0;

  int busyLeft = 0; bit stsErrBit = 0; logic [7:0] stsCodeV = '0;
  bit stallMode = 0, stallTog = 0;
  int irqDelay = 0, irqCnt = 0; bit irqArm = 0;
  logic [11:0] logA [0:39]; logic [31:0] logD [0:39]; logic logW [0:39]; int logN = 0;
  logic [11:0] expA [0:39]; logic [31:0] expD [0:39]; logic expW [0:39]; int expN = 0;

  mbox_cmd_seq #(.POLL_LIMIT(PL), .IRQ_WAIT(IW)) u_mbox_cmd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSimple(reqSimple),
    .reqUseIrq(reqUseIrq), .reqCmd(reqCmd), .reqSub(reqSub), .reqInLen(reqInLen),
    .reqOutCnt(reqOutCnt), .reqData(reqData), .reqDstPtr(reqDstPtr),
    .reqSrcPtr(reqSrcPtr), .busy(busy), .done(done), .result(result),
    .outData(outData), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .busReady(busReady),
    .busRData(busRData), .cmpIrq(cmpIrq)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] rdWord(int i);
    return 32'hC0DE0000 | 32'(i);
  endfunction

  // responder model: decides ready and read data away from the active edge
  always @(negedge clk) begin
    cmpIrq = 1'b0;
    if (irqArm) begin
      if (irqCnt == irqDelay) begin cmpIrq = 1'b1; irqArm = 0; end
      irqCnt++;
    end
    busReady = 1'b0; busRData = '0;
    if (rstN && busValid) begin
      if (stallMode && !stallTog) stallTog = 1;
      else begin
        stallTog = 0; busReady = 1'b1;
        if (!busWrite) begin
          if (busAddr == 12'h004) begin
            busRData = {8'h00, stsCodeV, 14'h0, 1'(stsErrBit), 1'(busyLeft > 0)};
            if (busyLeft > 0) busyLeft--;
          end else if (busAddr >= 12'h090 && busAddr < 12'h0A0)
            busRData = rdWord((int'(busAddr) - 'h90) / 4);
        end
        if (logN < 40) begin
          logA[logN] = busAddr; logW[logN] = busWrite; logD[logN] = busWData; logN++;
        end
        if (busWrite && busAddr == 12'h000 && irqDelay > 0) begin irqArm = 1; irqCnt = 1; end
      end
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clearLogs();
    logN = 0; expN = 0;
  endtask

  task automatic pushExp(logic w, logic [11:0] a, logic [31:0] d);
    expW[expN] = w; expA[expN] = a; expD[expN] = d; expN++;
  endtask

  task automatic cmpLog(string tag);
    chk({tag, " access count"}, 128'(logN), 128'(expN));
    for (int i = 0; i < expN && i < logN; i++) begin
      chk({tag, " access kind/addr"}, {logW[i], logA[i]}, {expW[i], expA[i]});
      if (expW[i]) chk({tag, " write data"}, logD[i], expD[i]);
    end
  endtask

  task automatic setReq(bit simple, bit irq, logic [7:0] c, logic [3:0] s,
                        int inLen, int outCnt);
    reqSimple = simple; reqUseIrq = irq; reqCmd = c; reqSub = s;
    reqInLen = 5'(inLen); reqOutCnt = 3'(outCnt);
  endtask

  task automatic runReq();
    @(negedge clk) reqValid = 1'b1;
    @(negedge clk) reqValid = 1'b0;
    for (int n = 0; n < 400 && !done; n++) @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R11 done after reset", done, 0);
    chk("R1 no bus access after reset", busValid, 0);
  endtask

  task automatic t_full_poll();
    clearLogs(); busyLeft = 2; stsErrBit = 0; stallMode = 1; irqDelay = 0;
    setReq(0, 0, 8'h3C, 4'h5, 7, 3);
    reqDstPtr = 32'hD000_0100; reqSrcPtr = 32'h5000_0200;
    @(negedge clk) reqValid = 1'b1;
    @(negedge clk) reqValid = 1'b0;
    @(negedge clk) reqValid = 1'b1; reqCmd = 8'h77;   // R1: ignored while busy
    @(negedge clk) reqValid = 1'b0;
    for (int n = 0; n < 400 && !done; n++) @(negedge clk);
    pushExp(1, 12'h00C, 32'hD000_0100);
    pushExp(1, 12'h008, 32'h5000_0200);
    pushExp(1, 12'h080, reqData[31:0]);
    pushExp(1, 12'h084, reqData[63:32]);
    pushExp(1, 12'h000, 32'h0007_503C);
    for (int i = 0; i < 3; i++) pushExp(0, 12'h004, 0);
    for (int i = 0; i < 3; i++) pushExp(0, 12'(16'h090 + 4 * i), 0);
    chk("R9 done seen", done, 1);
    chk("R9 result ok", result, 0);
    chk("R9 reply words", outData, {32'h0, rdWord(2), rdWord(1), rdWord(0)});
    cmpLog("R3 R4 R6 R1 full sequence");
    settle();
    chk("R1 idle after done", {busy, busValid}, 0);
    chk("R1 no second transaction", 128'(logN), 128'(expN));
    chk("R11 result held", result, 0);
    stallMode = 0;
  endtask

  task automatic t_invalid();
    clearLogs();
    setReq(0, 0, 8'h11, 4'h1, 17, 0); runReq();
    chk("R2 long input rejected", result, 1);
    settle();
    setReq(0, 0, 8'h11, 4'h1, 16, 5); runReq();
    chk("R2 long output rejected", result, 1);
    cmpLog("R2 no access");
    settle();
  endtask

  task automatic t_boundary();
    clearLogs(); busyLeft = 0; irqDelay = 2;
    setReq(0, 1, 8'h5A, 4'h2, 16, 4);
    reqDstPtr = 32'h1111_2222; reqSrcPtr = 32'h3333_4444;
    runReq();
    pushExp(1, 12'h00C, 32'h1111_2222);
    pushExp(1, 12'h008, 32'h3333_4444);
    for (int i = 0; i < 4; i++) pushExp(1, 12'(16'h080 + 4 * i), reqData[32*i +: 32]);
    pushExp(1, 12'h000, 32'h0010_215A);
    pushExp(0, 12'h004, 0);
    for (int i = 0; i < 4; i++) pushExp(0, 12'(16'h090 + 4 * i), 0);
    chk("R9 full reply ok", result, 0);
    chk("R9 four words", outData, {rdWord(3), rdWord(2), rdWord(1), rdWord(0)});
    cmpLog("R3 R4 R7 max lengths irq");
    settle();
    clearLogs(); irqDelay = 0;
    setReq(0, 0, 8'h42, 4'h0, 0, 0); runReq();
    pushExp(1, 12'h00C, 32'h1111_2222);
    pushExp(1, 12'h008, 32'h3333_4444);
    pushExp(1, 12'h000, 32'h0000_0042);
    pushExp(0, 12'h004, 0);
    chk("R3 empty input ok", result, 0);
    cmpLog("R3 zero data words");
    settle();
  endtask

  task automatic t_simple();
    clearLogs(); busyLeft = 1; irqDelay = 0;
    setReq(1, 0, 8'hA1, 4'h9, 20, 7); runReq();
    pushExp(1, 12'h000, 32'h0000_90A1);
    pushExp(0, 12'h004, 0); pushExp(0, 12'h004, 0);
    chk("R5 simple ok despite lengths", result, 0);
    chk("R5 no reply words", outData, 0);
    cmpLog("R5 command only");
    settle();
  endtask

  task automatic t_poll_limit();
    clearLogs(); busyLeft = PL - 1;
    setReq(1, 0, 8'hA1, 4'h9, 0, 0); runReq();
    chk("R6 clear on last poll", result, 0);
    settle();
    busyLeft = PL; runReq();
    chk("R6 poll timeout", result, 2);
    pushExp(1, 12'h000, 32'h0000_90A1);
    for (int i = 0; i < PL; i++) pushExp(0, 12'h004, 0);
    pushExp(1, 12'h000, 32'h0000_90A1);
    for (int i = 0; i < PL; i++) pushExp(0, 12'h004, 0);
    cmpLog("R6 poll reads");
    busyLeft = 0; settle();
  endtask

  task automatic t_irq_edge();
    clearLogs(); busyLeft = 0; irqDelay = IW;
    setReq(1, 1, 8'hA1, 4'h9, 0, 0); runReq();
    chk("R7 pulse in last cycle ok", result, 0);
    pushExp(1, 12'h000, 32'h0000_91A1); pushExp(0, 12'h004, 0);
    cmpLog("R7 R4 last-cycle pulse");
    settle();
    clearLogs(); irqDelay = IW + 1; runReq();
    chk("R7 late pulse timeout", result, 2);
    pushExp(1, 12'h000, 32'h0000_91A1);
    settle();
    cmpLog("R7 no read after timeout");
    irqDelay = 0;
  endtask

  task automatic t_errors();
    logic [7:0] codes [4] = '{8'd6, 8'd7, 8'd5, 8'd8};
    logic [2:0] expR  [4] = '{3'd4, 3'd4, 3'd3, 3'd3};
    busyLeft = 0; stsErrBit = 1; irqDelay = 0;
    for (int k = 0; k < 4; k++) begin
      stsCodeV = codes[k];
      setReq(1, 0, 8'hA1, 4'h9, 0, 0); runReq();
      chk($sformatf("R8 code %0d", codes[k]), result, expR[k]);
      settle();
    end
    clearLogs(); stsCodeV = 8'd3;
    setReq(0, 0, 8'h42, 4'h0, 0, 2); runReq();
    chk("R8 generic error", result, 3);
    chk("R8 no reply words", outData, 0);
    pushExp(1, 12'h00C, 32'h1111_2222);
    pushExp(1, 12'h008, 32'h3333_4444);
    pushExp(1, 12'h000, 32'h0000_0042);
    pushExp(0, 12'h004, 0);
    cmpLog("R8 no readback on error");
    stsErrBit = 0; settle();
  endtask

  initial begin
    for (int k = 0; k < 16; k++) reqData[8*k +: 8] = 8'(8'h10 + k);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_poll();
    t_invalid();
    t_boundary();
    t_simple();
    t_poll_limit();
    t_irq_edge();
    t_errors();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule